// File: doc/BRIEF.md
# Cluster Coherency Register Block

This block is the register front end of a cluster controller that serves from one to four processor cores. A simple bus slave reaches it. Each access gives a request strobe, a write flag, a byte address, an access size in bytes and write data. Reads return registered data one clock later.

The block holds three things. The first is a single enable bit. The second is a constant configuration word derived from the core-count parameter. The third is a 32-bit power status word. Any of the four byte offsets of the power status word may be written with a 1, 2 or 4 byte access, and the write is merged under a byte mask built from the size. All other offsets read as zero and drop writes. A write whose size is not 1, 2 or 4 is refused and changes nothing.

Top module: `ccu_reg_block`

## Requirements
- R1: A write of valid size to address 0x00 stores bit 0 of the write data as the enable bit. A read of 0x00 returns that bit in bit 0 and zero in bits 31:1. The enable bit resets to 0.
- R2: A read of 0x04 returns a configuration word. Bits 1:0 hold NUM_CORES-1. Bits 4 through 4+NUM_CORES-1 are set. All other bits are 0. Writes to 0x04 change no readable state.
- R3: A read at address 0x08+k (k = 0..3) returns the power status word shifted right by 8*k bits, with zeros filling from the top.
- R4: A write at 0x08+k with size s (1, 2 or 4 bytes) replaces bytes k to k+s-1 of the power status word with the low s bytes of the write data. The other bytes keep their values. Any byte that would land above bit 31 is discarded.
- R5: A write whose size field (a binary byte count) is not 1, 2 or 4 leaves the enable bit and the power status word unchanged.
- R6: Addresses 0x0C, 0x40 and 0x44, and every address not named in R1 to R4, read as zero. Writes to these addresses change no readable state.
- R7: The power status word resets to zero.
- R8: Read data is registered. It shows the addressed value one clock after a read request and holds when no read request is made. A write does not change it. Read data resets to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_size | input | 3 | Access size as a byte count (valid: 1, 2, 4) |
| bus_wdata | input | 32 | Write data, right aligned |
| bus_rdata | output | 32 | Registered read data |

## Verification
Directed power-word writes set a known pattern first. A single-byte write then tells a correct lane merge apart from a whole-word overwrite. A 4-byte write at offset 0x0B shows whether bytes above bit 31 are dropped or wrap into the low bytes. Writes of sizes 0, 3 and 5 to 7 tell a size-checked write apart from one that only decodes the address. Constrained random traffic then mixes every mapped offset, a few unmapped ones and all eight size codes, and compares each read against a bench model of the merge rule.

// File: rtl/ccu_regs_pkg.sv
package ccu_regs_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = $clog2(LANES);

    localparam int OFF_CTRL = 'h00;
    localparam int OFF_CFG  = 'h04;
    localparam int OFF_PWR  = 'h08;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_CTRL = 2'd1,
        TGT_CFG  = 2'd2,
        TGT_PWR  = 2'd3
    } target_e;

    typedef struct packed {
        target_e             tgt;
        logic [LANE_W-1:0]   lane;
        logic                size_ok;
        logic [LANES-1:0]    size_be;
    } dec_t;

    // byte enables for a right-aligned access of the given byte count
    function automatic logic [LANES-1:0] size_to_be(input logic [2:0] sz);
        logic [LANES-1:0] be;
        case (sz)
            3'd1:    be = LANES'(4'b0001);
            3'd2:    be = LANES'(4'b0011);
            3'd4:    be = LANES'(4'b1111);
            default: be = '0;
        endcase
        return be;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_word(input int n);
        logic [DATA_W-1:0] w;
        w      = '0;
        w[1:0] = 2'(n - 1);
        for (int i = 0; i < n; i++) begin
            w[4 + i] = 1'b1;
        end
        return w;
    endfunction

endpackage

// File: rtl/ccu_bus_decode.sv
module ccu_bus_decode
    import ccu_regs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        size,
    output dec_t              dec
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFF_CFG);
    localparam logic [ADDR_W-1:0] A_PWR  = ADDR_W'(OFF_PWR);

    logic [ADDR_W-1:0] pwr_rel;

    assign pwr_rel = addr - A_PWR;

    always_comb begin
        dec.size_be = size_to_be(size);
        dec.size_ok = |dec.size_be;
        dec.lane    = '0;
        if (addr == A_CTRL) begin
            dec.tgt = TGT_CTRL;
        end else if (addr == A_CFG) begin
            dec.tgt = TGT_CFG;
        end else if (addr >= A_PWR && pwr_rel < ADDR_W'(LANES)) begin
            dec.tgt  = TGT_PWR;
            dec.lane = pwr_rel[LANE_W-1:0];
        end else begin
            dec.tgt = TGT_NONE;
        end
    end

endmodule

// File: rtl/ccu_power_word.sv
module ccu_power_word
    import ccu_regs_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [LANE_W-1:0]   lane,
    input  logic [LANES-1:0]    size_be,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   word_q
);

    logic [2*LANES-1:0] be_wide;
    logic [LANES-1:0]   be_sh;
    logic [DATA_W-1:0]  wd_sh;
    logic [DATA_W-1:0]  word_d;

    // shift enables by the lane offset, dropping any that pass the top byte
    assign be_wide = {{LANES{1'b0}}, size_be} << lane;
    assign be_sh   = be_wide[LANES-1:0];
    assign wd_sh   = wdata << {lane, 3'b000};

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign word_d[8*b +: 8] = (wr_en && be_sh[b]) ? wd_sh[8*b +: 8]
                                                      : word_q[8*b +: 8];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    p_hold_no_write_r4: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(word_q));

    p_top_lane_keeps_low_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && lane == LANE_W'(LANES - 1)) |=>
            word_q[DATA_W-9:0] == $past(word_q[DATA_W-9:0]));

endmodule

// File: rtl/ccu_read_mux.sv
module ccu_read_mux
    import ccu_regs_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_en,
    input  target_e             tgt,
    input  logic [LANE_W-1:0]   lane,
    input  logic                ctrl_q,
    input  logic [DATA_W-1:0]   cfg,
    input  logic [DATA_W-1:0]   pwr_word,
    output logic [DATA_W-1:0]   rdata
);

    logic [DATA_W-1:0] rd_val;

    always_comb begin
        case (tgt)
            TGT_CTRL: rd_val = {{(DATA_W-1){1'b0}}, ctrl_q};
            TGT_CFG:  rd_val = cfg;
            TGT_PWR:  rd_val = pwr_word >> {lane, 3'b000};
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_val;
        end
    end

    p_unmapped_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && tgt == TGT_NONE) |=> rdata == '0);

    p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

endmodule

// File: rtl/ccu_reg_block.sv
module ccu_reg_block
    import ccu_regs_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [2:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);

    localparam logic [DATA_W-1:0] CFG_VAL = cfg_word(NUM_CORES);

    dec_t              dec;
    logic              wr_ok;
    logic              rd_en;
    logic              ctrl_q;
    logic [DATA_W-1:0] pwr_word;

    assign wr_ok = bus_req && bus_wr && dec.size_ok;
    assign rd_en = bus_req && !bus_wr;

    ccu_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .size (bus_size),
        .dec  (dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= 1'b0;
        end else if (wr_ok && dec.tgt == TGT_CTRL) begin
            ctrl_q <= bus_wdata[0];
        end
    end

    ccu_power_word u_pwr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_ok && dec.tgt == TGT_PWR),
        .lane    (dec.lane),
        .size_be (dec.size_be),
        .wdata   (bus_wdata),
        .word_q  (pwr_word)
    );

    ccu_read_mux u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .tgt      (dec.tgt),
        .lane     (dec.lane),
        .ctrl_q   (ctrl_q),
        .cfg      (CFG_VAL),
        .pwr_word (pwr_word),
        .rdata    (bus_rdata)
    );

    p_ctrl_read_narrow_r1: assert property (@(posedge clk) disable iff (rst)
        (rd_en && bus_addr == '0) |=> bus_rdata[31:1] == '0);

    p_bad_size_no_change_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_wr && bus_size != 3'd1 && bus_size != 3'd2 && bus_size != 3'd4)
            |=> ($stable(pwr_word) && $stable(ctrl_q)));

    p_write_keeps_rdata_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_wr) |=> $stable(bus_rdata));

endmodule

// File: tb/ccu_reg_block_tb.sv
module ccu_reg_block_tb;

    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [2:0]  bus_size = 3'd4;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic        m_ctrl;
    logic [31:0] m_pwr;

    always #10 clk = ~clk;

    ccu_reg_block #(.NUM_CORES(NC), .ADDR_W(8)) u_dut (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] exp_cfg();
        logic [31:0] w = '0;
        w[1:0] = 2'(NC - 1);
        for (int i = 0; i < NC; i++) w[4+i] = 1'b1;
        return w;
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        if (a == 8'h00) return {31'b0, m_ctrl};
        if (a == 8'h04) return exp_cfg();
        if (a >= 8'h08 && a <= 8'h0B) return m_pwr >> (8 * (a - 8'h08));
        return 32'h0;
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [2:0] sz, input logic [31:0] d);
        int nb;
        int k;
        if (sz == 3'd1) nb = 1;
        else if (sz == 3'd2) nb = 2;
        else if (sz == 3'd4) nb = 4;
        else nb = 0;
        if (nb == 0) return;
        if (a == 8'h00) m_ctrl = d[0];
        if (a >= 8'h08 && a <= 8'h0B) begin
            k = int'(a - 8'h08);
            for (int i = 0; i < nb; i++) begin
                if (k + i < 4) m_pwr[8*(k+i) +: 8] = d[8*i +: 8];
            end
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [2:0] sz, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_wr = 1'b0;
        model_write(a, sz, d);
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_size = 3'd4;
        @(negedge clk);
        bus_req = 1'b0;
        v = bus_rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a);
        logic [31:0] v;
        do_read(a, v);
        chk(tag, v, exp_read(a));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual=hung expected=finish");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  addrs [12];
        void'($urandom(32'd20240611));
        m_ctrl = 1'b0;
        m_pwr  = '0;
        addrs = '{8'h00, 8'h04, 8'h08, 8'h09, 8'h0A, 8'h0B,
                  8'h0C, 8'h40, 8'h44, 8'h01, 8'h10, 8'hFF};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R8 reset rdata", bus_rdata, 32'h0);
        rd_chk("R1 ctrl reset", 8'h00);
        rd_chk("R7 power reset", 8'h08);
        do_read(8'h04, v);
        chk("R2 config value", v, 32'h000000F3);

        do_write(8'h00, 3'd4, 32'hFFFF_FFFF);
        rd_chk("R1 ctrl set", 8'h00);
        do_write(8'h00, 3'd1, 32'h0000_0002);
        rd_chk("R1 ctrl only bit0", 8'h00);
        do_write(8'h04, 3'd4, 32'hFFFF_FFFF);
        do_read(8'h04, v);
        chk("R2 config write ignored", v, 32'h000000F3);

        do_write(8'h08, 3'd4, 32'h1234_5678);
        do_read(8'h08, v); chk("R3 off0", v, 32'h1234_5678);
        do_read(8'h09, v); chk("R3 off1", v, 32'h0012_3456);
        do_read(8'h0A, v); chk("R3 off2", v, 32'h0000_1234);
        do_read(8'h0B, v); chk("R3 off3", v, 32'h0000_0012);

        do_write(8'h0A, 3'd1, 32'hFFFF_FFAB);
        do_read(8'h08, v); chk("R4 byte merge", v, 32'h12AB_5678);
        do_write(8'h0B, 3'd4, 32'hCAFE_F00D);
        do_read(8'h08, v); chk("R4 overflow dropped", v, 32'h0DAB_5678);
        do_write(8'h09, 3'd2, 32'h1111_BEEF);
        do_read(8'h08, v); chk("R4 halfword merge", v, 32'h0DBE_EF78);

        do_write(8'h08, 3'd3, 32'h0);
        do_write(8'h08, 3'd0, 32'h0);
        do_write(8'h00, 3'd5, 32'h1);
        do_write(8'h0B, 3'd7, 32'h0);
        do_read(8'h08, v); chk("R5 bad size power", v, 32'h0DBE_EF78);
        do_read(8'h00, v); chk("R5 bad size ctrl", v, 32'h0);

        do_write(8'h00, 3'd1, 32'h1);
        do_write(8'h0C, 3'd4, 32'hFFFF_FFFF);
        do_write(8'h40, 3'd4, 32'hFFFF_FFFF);
        do_write(8'h44, 3'd4, 32'h0);
        do_write(8'h10, 3'd4, 32'h0);
        rd_chk("R6 invalidate reads zero", 8'h0C);
        rd_chk("R6 filter start zero", 8'h40);
        rd_chk("R6 filter end zero", 8'h44);
        rd_chk("R6 unlisted zero", 8'h02);
        do_read(8'h08, v); chk("R6 power unchanged", v, 32'h0DBE_EF78);
        do_read(8'h00, v); chk("R6 ctrl unchanged", v, 32'h1);

        do_read(8'h08, v);
        @(negedge clk);
        chk("R8 hold idle", bus_rdata, 32'h0DBE_EF78);
        do_write(8'h08, 3'd4, 32'h0);
        chk("R8 write leaves rdata", bus_rdata, 32'h0DBE_EF78);

        for (int n = 0; n < 600; n++) begin
            logic [7:0]  a;
            logic [2:0]  sz;
            logic [31:0] d;
            a  = addrs[$urandom % 12];
            if (a == 8'hFF) a = 8'($urandom);
            sz = 3'($urandom);
            d  = $urandom;
            if ($urandom % 2 == 0) begin
                do_write(a, sz, d);
            end else begin
                rd_chk("R3 R4 random read", a);
            end
        end
        rd_chk("R4 final word", 8'h08);
        finish_run();
    end

endmodule